// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is a single 32-bit timer channel that counts down and, when it passes zero, refills itself from a 32-bit reload register. It then keeps counting from that value. Software picks the count source with a 3-bit source code. Four codes give fixed divisions of the peripheral clock: 4, 16, 64 or 256. One code gives a real-time clock tick input. One code gives an external pin. For the pin, a 2-bit edge field chooses rising edges, falling edges or both. The two remaining codes are reserved and stop the count.

Each underflow sets a sticky status flag. Software clears the flag by writing 0 to it. The interrupt output is high while the flag is set and the interrupt enable bit is on. A start bit gates counting. All inputs are synchronous to the peripheral clock. The tick input and the pin input each pass through a two-stage synchronizer before edge detection.

Access is through a small register interface: a write strobe, a 2-bit address, write data, and read data that follows the address combinationally.

Top module: `dcount_timer`

## Requirements
- R1: After reset the control register reads 0, the counter and the reload register both read 0xFFFFFFFF, and irq is low.
- R2: Address 0 is the control register: bit 0 start, bits 3:1 source code, bits 5:4 edge select, bit 6 interrupt enable, bit 7 underflow flag. Address 1 is the counter and address 2 is the reload register. Address 3 reads 0. Written values read back.
- R3: While started, source codes 000, 001, 010 and 011 decrement the counter exactly once every 4, 16, 64 and 256 peripheral clock cycles respectively.
- R4: While the start bit is 0, the counter keeps the value software last wrote to it.
- R5: A count event that finds the counter at zero loads the counter from the reload register, with no wrap to all ones, and sets the underflow flag.
- R6: Source codes 110 and 111 produce no count events, even with the start bit set.
- R7: Source code 100 decrements the counter once per rising edge of the tick input.
- R8: Source code 101 counts pin transitions as set by the edge field: 00 counts rising edges, 01 counts falling edges, and 10 or 11 counts both.
- R9: Writing 0 to the flag bit clears it. Writing 1 leaves it unchanged. If an underflow happens in the same cycle as a clearing write, the flag stays set.
- R10: irq is high exactly when the underflow flag and the interrupt enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for regAddr |
| rtcTick | input | 1 | Real-time clock tick input |
| extClkPin | input | 1 | External count pin |
| irq | output | 1 | Underflow interrupt |

## Verification
A wrong prescaler phase or a wrong source selection shows up as a counter value that is off after a whole number of division periods. That error is visible at the next counter read. A fault in the synchronizer or edge detector shows up as a miscounted pulse train once the pulses have settled, about three cycles after the last transition. A bad flag or reload path shows up one cycle after the underflow, in the counter value, the flag bit and irq. The one case that needs exact timing is a flag clear landing on the same edge as an underflow. The bench places it there through the pin input, because the pin's latency through the synchronizer is known.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CONST = 2'd2;

  // control register field positions
  localparam int BIT_START = 0;
  localparam int SEL_LO    = 1;
  localparam int SEL_HI    = 3;
  localparam int EDGE_LO   = 4;
  localparam int EDGE_HI   = 5;
  localparam int BIT_IE    = 6;
  localparam int BIT_FLAG  = 7;

  typedef struct packed {
    logic countEn;
    logic wrCount;
    logic wrConst;
  } dpStrobe_t;

endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int NUM_DIV  = 4,
  parameter int DIV_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CTRL_W-1:0] wrByte,
  input  logic              rtcTick,
  input  logic              extPin,
  input  logic              underflow,
  output dpStrobe_t         strobes,
  output logic [CTRL_W-1:0] ctrlWord,
  output logic              irq
);

  localparam int PRE_W = NUM_DIV * DIV_STEP;
  localparam int SEL_W = SEL_HI - SEL_LO + 1;
  localparam logic [SEL_W-1:0] SEL_RTC = SEL_W'(NUM_DIV);
  localparam logic [SEL_W-1:0] SEL_EXT = SEL_W'(NUM_DIV + 1);

  logic             startQ, ieQ, flagQ;
  logic [SEL_W-1:0] selQ;
  logic [1:0]       edgeQ;
  logic [PRE_W-1:0] preCnt;
  logic [NUM_DIV-1:0] divTick;
  logic [2:0]       rtcSync, extSync;
  logic             rtcRise, extRise, extFall, extHit, srcTick;
  logic             wrCtrl;

  assign wrCtrl = wrEn && (addr == ADDR_CTRL);

  // free-running prescaler; each division taps its low bits
  always_ff @(posedge clk) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_DIV; g++) begin : gDiv
      assign divTick[g] = &preCnt[DIV_STEP*(g+1)-1:0];
    end
  endgenerate

  // two-stage synchronizers plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rtcSync <= '0;
      extSync <= '0;
    end else begin
      rtcSync <= {rtcSync[1:0], rtcTick};
      extSync <= {extSync[1:0], extPin};
    end
  end

  assign rtcRise = rtcSync[1] & ~rtcSync[2];
  assign extRise = extSync[1] & ~extSync[2];
  assign extFall = ~extSync[1] & extSync[2];

  always_comb begin
    if (edgeQ[1])      extHit = extRise | extFall;
    else if (edgeQ[0]) extHit = extFall;
    else               extHit = extRise;
  end

  always_comb begin
    srcTick = 1'b0;
    if (selQ < SEL_RTC)       srcTick = divTick[selQ[$clog2(NUM_DIV)-1:0]];
    else if (selQ == SEL_RTC) srcTick = rtcRise;
    else if (selQ == SEL_EXT) srcTick = extHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= 1'b0;
      selQ   <= '0;
      edgeQ  <= '0;
      ieQ    <= 1'b0;
    end else if (wrCtrl) begin
      startQ <= wrByte[BIT_START];
      selQ   <= wrByte[SEL_HI:SEL_LO];
      edgeQ  <= wrByte[EDGE_HI:EDGE_LO];
      ieQ    <= wrByte[BIT_IE];
    end
  end

  // sticky flag: a write of 0 clears it, and an underflow in the same cycle wins
  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= 1'b0;
    else       flagQ <= underflow | (flagQ & ~(wrCtrl & ~wrByte[BIT_FLAG]));
  end

  assign strobes.countEn = startQ & srcTick;
  assign strobes.wrCount = wrEn && (addr == ADDR_COUNT);
  assign strobes.wrConst = wrEn && (addr == ADDR_CONST);

  assign ctrlWord = {flagQ, ieQ, edgeQ, selQ, startQ};
  assign irq      = flagQ & ieQ;

endmodule

// File: rtl/timer_dp.sv
module timer_dp
  import timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] countVal,
  output logic [DATA_W-1:0] reloadVal,
  output logic              underflow
);

  assign underflow = strobes.countEn && (countVal == '0);

  always_ff @(posedge clk) begin
    if (!rstN)                countVal <= '1;
    else if (strobes.wrCount) countVal <= wrData;
    else if (underflow)       countVal <= reloadVal;
    else if (strobes.countEn) countVal <= countVal - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                reloadVal <= '1;
    else if (strobes.wrConst) reloadVal <= wrData;
  end

endmodule

// File: rtl/dcount_timer.sv
module dcount_timer
  import timer_pkg::*;
#(
  parameter int NUM_DIV  = 4,
  parameter int DIV_STEP = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              rtcTick,
  input  logic              extClkPin,
  output logic              irq
);

  dpStrobe_t         strobes;
  logic [CTRL_W-1:0] ctrlWord;
  logic [DATA_W-1:0] countVal, reloadVal;
  logic              underflow;

  timer_ctrl #(.NUM_DIV(NUM_DIV), .DIV_STEP(DIV_STEP)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr),
    .wrByte(regWrData[CTRL_W-1:0]), .rtcTick(rtcTick), .extPin(extClkPin),
    .underflow(underflow), .strobes(strobes), .ctrlWord(ctrlWord), .irq(irq)
  );

  timer_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(regWrData),
    .countVal(countVal), .reloadVal(reloadVal), .underflow(underflow)
  );

  always_comb begin
    case (regAddr)
      ADDR_CTRL:  regRdData = {{(DATA_W-CTRL_W){1'b0}}, ctrlWord};
      ADDR_COUNT: regRdData = countVal;
      ADDR_CONST: regRdData = reloadVal;
      default:    regRdData = '0;
    endcase
  end

endmodule

// File: rtl/timer_chk.sv
module timer_chk
  import timer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              countEn,
  input logic              wrCount,
  input logic              underflow,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] reloadVal,
  input logic [CTRL_W-1:0] ctrlWord,
  input logic              wrCtrl,
  input logic              irq
);

  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rstN)
    (countEn && count != '0 && !wrCount) |=> count == $past(count) - 1'b1);

  assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlWord[BIT_START] && !wrCount) |=> $stable(count));

  assert_reload_R5: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !wrCount) |=> count == $past(reloadVal));

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    underflow |=> ctrlWord[BIT_FLAG]);

  assert_reserved_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[SEL_HI:SEL_LO] >= 3'd6) |-> !countEn);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[BIT_FLAG] && !wrCtrl) |=> ctrlWord[BIT_FLAG]);

  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (ctrlWord[BIT_IE] && ctrlWord[BIT_FLAG]));

  assert_irq_follows_flag_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWord[BIT_IE] && ctrlWord[BIT_FLAG]) |-> irq);

endmodule

bind dcount_timer timer_chk u_chk (
  .clk(clk), .rstN(rstN), .countEn(strobes.countEn), .wrCount(strobes.wrCount),
  .underflow(underflow), .count(countVal), .reloadVal(reloadVal),
  .ctrlWord(ctrlWord), .wrCtrl(regWrEn && (regAddr == 2'd0)), .irq(irq)
);

// File: tb/sim_dcount_timer.sv
`timescale 1ns/1ps
module sim_dcount_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        rtcTick = 1'b0;
  logic        extClkPin = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  dcount_timer u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .rtcTick(rtcTick),
    .extClkPin(extClkPin), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pinPulses(input int n);
    for (int i = 0; i < n; i++) begin
      extClkPin = 1'b1; idle(3);
      extClkPin = 1'b0; idle(3);
    end
    idle(4);
  endtask

  task automatic testReset();
    logic [31:0] v;
    rd(2'd0, v); check("R1 ctrl", v, 32'h0);
    rd(2'd1, v); check("R1 counter", v, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R1 reload", v, 32'hFFFF_FFFF);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic testRegMap();
    logic [31:0] v;
    wr(2'd2, 32'h1234_5678);
    wr(2'd1, 32'hCAFE_0001);
    wr(2'd0, 32'h0000_007E);  // start 0, sel 7, edge 3, ie 1
    rd(2'd2, v); check("R2 reload readback", v, 32'h1234_5678);
    rd(2'd1, v); check("R2 counter readback", v, 32'hCAFE_0001);
    rd(2'd0, v); check("R2 ctrl readback", v, 32'h0000_007E);
    rd(2'd3, v); check("R2 unused address", v, 32'h0);
    wr(2'd0, 32'h0);
  endtask

  task automatic testStopped();
    logic [31:0] v;
    wr(2'd1, 32'd777);
    idle(300);
    rd(2'd1, v); check("R4 stopped hold", v, 32'd777);
  endtask

  task automatic testDivisions();
    logic [31:0] v;
    for (int c = 0; c < 4; c++) begin
      int div = 4 << (2 * c);
      wr(2'd0, 32'h0);
      wr(2'd1, 32'd1000);
      wr(2'd0, 32'(1 | (c << 1)));
      idle(3 * div);
      rd(2'd1, v);
      check($sformatf("R3 division code %0d", c), v, 32'd997);
    end
    wr(2'd0, 32'h0);
  endtask

  task automatic testReserved();
    logic [31:0] v;
    for (int c = 6; c < 8; c++) begin
      wr(2'd1, 32'd55);
      wr(2'd0, 32'(1 | (c << 1)));
      rtcTick = 1'b1; extClkPin = 1'b1; idle(5);
      rtcTick = 1'b0; extClkPin = 1'b0; idle(300);
      rd(2'd1, v);
      check($sformatf("R6 reserved code %0d", c), v, 32'd55);
      wr(2'd0, 32'h0);
    end
  endtask

  task automatic testRtc();
    logic [31:0] v;
    wr(2'd1, 32'd50);
    wr(2'd0, 32'h9);  // start, sel 100
    for (int i = 0; i < 5; i++) begin
      rtcTick = 1'b1; idle(3);
      rtcTick = 1'b0; idle(3);
    end
    idle(4);
    rd(2'd1, v); check("R7 rtc ticks", v, 32'd45);
    wr(2'd0, 32'h0);
  endtask

  task automatic testExtEdges();
    logic [31:0] v;
    wr(2'd1, 32'd100);
    wr(2'd0, 32'h0B);  // sel 101, rising
    pinPulses(4);
    rd(2'd1, v); check("R8 rising edges", v, 32'd96);
    wr(2'd0, 32'h1B);  // falling
    pinPulses(3);
    rd(2'd1, v); check("R8 falling edges", v, 32'd93);
    wr(2'd0, 32'h2B);  // both
    pinPulses(5);
    rd(2'd1, v); check("R8 both edges", v, 32'd83);
    wr(2'd0, 32'h0);
  endtask

  task automatic testUnderflow();
    logic [31:0] v;
    wr(2'd2, 32'd10);
    wr(2'd1, 32'd2);
    wr(2'd0, 32'h41);  // start, div 4, ie
    idle(12);
    rd(2'd1, v); check("R5 reload on underflow", v, 32'd10);
    rd(2'd0, v); check("R5 flag set", v, 32'hC1);
    check("R10 irq with enable", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'hC0);  // stop, flag written as 1
    rd(2'd0, v); check("R9 write 1 keeps flag", v, 32'hC0);
    wr(2'd0, 32'h80);  // ie off, flag kept
    check("R10 irq masked", {31'b0, irq}, 32'h0);
    wr(2'd0, 32'h40);  // clear flag
    rd(2'd0, v); check("R9 write 0 clears flag", v, 32'h40);
    check("R10 irq after clear", {31'b0, irq}, 32'h0);
    wr(2'd0, 32'h0);
  endtask

  task automatic testClearCollision();
    logic [31:0] v;
    wr(2'd2, 32'd5);
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h4B);  // start, ext rising, ie
    pinPulses(1);
    rd(2'd0, v); check("R5 ext underflow flag", v, 32'hCB);
    wr(2'd1, 32'd0);
    extClkPin = 1'b1;
    idle(2);
    wr(2'd0, 32'h4B);  // clear lands on the underflow edge
    rd(2'd0, v); check("R9 underflow beats clear", v, 32'hCB);
    rd(2'd1, v); check("R5 reload at collision", v, 32'd5);
    wr(2'd0, 32'h4B);
    rd(2'd0, v); check("R9 later clear", v, 32'h4B);
    extClkPin = 1'b0;
    idle(4);
    wr(2'd0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegMap();
    testStopped();
    testDivisions();
    testReserved();
    testRtc();
    testExtEdges();
    testUnderflow();
    testClearCollision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected<=150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule